// File: doc/BRIEF.md
# SPI Byte FIFO Pair with Threshold Flags

This block buffers data between a register bus and the serial shifter of a byte-wide SPI controller. It contains one 64-byte transmit queue and one 64-byte receive queue. Software pushes transmit bytes with bus writes and pops received bytes with bus reads. The shifter takes bytes out of the transmit queue and deposits received bytes into the receive queue. It does this through single-cycle request pulses, with an availability or space indication alongside each.

Two level-based event flags support interrupt-driven service. One flag reports that the receive queue is three-quarters full. The other reports that the transmit queue has drained to one quarter or less. Each flag is sticky, is cleared by writing a one to it, and drives the interrupt line only while its enable bit is set. Software can flush either queue on its own through two control bits. It can read both fill levels in a single status word.

Top module: `spi_fifo_pair`

## Requirements
- R1: Each queue holds up to 64 bytes. A push into a full queue is ignored, so its level stays at 64 and the stored bytes are unchanged.
- R2: A bus write to offset 0x04 pushes bits 7:0 into the transmit queue. Each `tx_pop` pulse removes the oldest byte, which `tx_byte` shows while `tx_avail` is high. Bytes leave in first-in first-out order.
- R3: A bus read of offset 0x00 returns the oldest received byte in bits 7:0 and removes it in the same cycle. A read of an empty receive queue returns 0 and changes nothing.
- R4: A read of offset 0x28 returns the receive level in bits 6:0 and the transmit level in bits 22:16. All other bits read as zero.
- R5: A bus write to offset 0x08 with bit 8 set empties the transmit queue, and with bit 9 set empties the receive queue. Each flush leaves the other queue untouched. A flush overrides a push or pop to the same queue in the same cycle.
- R6: Status bit 4 (offset 0x10) is set in the cycle after the receive level is 48 or more. It stays set until it is cleared.
- R7: Status bit 12 (offset 0x10) is set in the cycle after the transmit level is 16 or less. It stays set until it is cleared.
- R8: Writing a one to status bit 4 or bit 12 clears that bit at the next edge. Bits written as zero keep their value, and all-ones clears both. If the level condition still holds, the bit sets again one cycle later.
- R9: Offset 0x0C holds the enable bits at positions 4 and 12, which read back as written. No other bit of 0x0C is stored. `irq` is high exactly when some status bit and its enable bit are both set.
- R10: A `rx_push` while the receive queue is full is ignored. A `tx_pop` while the transmit queue is empty is ignored, and `tx_byte` reads 0 while `tx_avail` is low.
- R11: After reset both levels are 0, the enables are 0, and the status reads 0 in the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 6 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| tx_pop | input | 1 | Shifter takes one transmit byte |
| tx_avail | output | 1 | Transmit queue not empty |
| tx_byte | output | 8 | Oldest transmit byte, 0 when empty |
| rx_push | input | 1 | Shifter delivers one received byte |
| rx_byte | input | 8 | Received byte |
| rx_space | output | 1 | Receive queue not full |
| irq | output | 1 | Enabled pending flags, ORed |

## Verification
A pointer or level counter that goes wrong shows up at the ports at once. The level field at 0x28 would disagree with the number of pushes and pops, or the bytes would come out of `tx_byte` or offset 0x00 in the wrong order or with the wrong values. A sticky flag that is set at the wrong level would show on status bits 4 and 12 one cycle after the level crosses 48 or 16. The bench therefore sweeps every level from empty to full in both queues and compares these flags against the level after each single push or pop, at exact cycle offsets. A clear that is lost, or an enable decoded into the wrong bit, shows on `irq` in the next cycle.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;

    localparam logic [ADDR_W-1:0] OFS_RXDATA = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_TXDATA = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_IEN    = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_ISTAT  = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_LEVEL  = 6'h28;

    localparam int BIT_TX_FLUSH = 8;
    localparam int BIT_RX_FLUSH = 9;
    localparam int BIT_RX_HI    = 4;
    localparam int BIT_TX_LO    = 12;
    localparam int LVL_RX_LSB   = 0;
    localparam int LVL_TX_LSB   = 16;
    localparam int LVL_FIELD_W  = 7;

    typedef struct packed {
        logic rx_hi;
        logic tx_lo;
    } flag_pair_t;

endpackage

// File: rtl/sync_fifo.sv
module sync_fifo #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             push_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic [CNT_W-1:0] count_o,
    output logic             full_o,
    output logic             empty_o
);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
    } fifo_state_t;

    fifo_state_t s_d, s_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        do_push = push_i && (s_q.count != CNT_W'(DEPTH));
        do_pop  = pop_i && (s_q.count != '0);
        s_d     = s_q;
        if (flush_i) begin
            s_d = '0;
        end else begin
            if (do_push) s_d.wr_ptr = ptr_next(s_q.wr_ptr);
            if (do_pop)  s_d.rd_ptr = ptr_next(s_q.rd_ptr);
            s_d.count = s_q.count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (!flush_i && do_push) mem_q[s_q.wr_ptr] <= wdata_i;
    end

    assign count_o = s_q.count;
    assign full_o  = (s_q.count == CNT_W'(DEPTH));
    assign empty_o = (s_q.count == '0);
    assign rdata_o = empty_o ? '0 : mem_q[s_q.rd_ptr];

    p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CNT_W'(DEPTH));

    p_full_push_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i && !pop_i && !flush_i) |=> $stable(count_o));

    p_flush_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> empty_o);

    p_empty_pop_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && pop_i && !push_i && !flush_i) |=> empty_o);

endmodule

// File: rtl/level_flags.sv
module level_flags
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int RX_HI = (DEPTH * 3) / 4,
    localparam int TX_LO = DEPTH / 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_count_i,
    input  logic [CNT_W-1:0] tx_count_i,
    input  flag_pair_t       clr_i,
    input  logic             en_we_i,
    input  flag_pair_t       en_wdata_i,
    output flag_pair_t       stat_o,
    output flag_pair_t       en_o,
    output logic             irq_o
);

    typedef struct packed {
        flag_pair_t stat;
        flag_pair_t en;
    } flag_state_t;

    flag_state_t f_d, f_q;
    logic rx_cond, tx_cond;

    always_comb begin
        rx_cond = (rx_count_i >= CNT_W'(RX_HI));
        tx_cond = (tx_count_i <= CNT_W'(TX_LO));
        f_d = f_q;
        f_d.stat.rx_hi = clr_i.rx_hi ? 1'b0 : (f_q.stat.rx_hi | rx_cond);
        f_d.stat.tx_lo = clr_i.tx_lo ? 1'b0 : (f_q.stat.tx_lo | tx_cond);
        if (en_we_i) f_d.en = en_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign stat_o = f_q.stat;
    assign en_o   = f_q.en;
    assign irq_o  = (f_q.stat.rx_hi & f_q.en.rx_hi) | (f_q.stat.tx_lo & f_q.en.tx_lo);

    p_rx_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_count_i >= CNT_W'(RX_HI)) && !clr_i.rx_hi) |=> stat_o.rx_hi);

    p_tx_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_count_i <= CNT_W'(TX_LO)) && !clr_i.tx_lo) |=> stat_o.tx_lo);

    p_clear_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i.rx_hi |=> !stat_o.rx_hi);

    p_clear_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i.tx_lo |=> !stat_o.tx_lo);

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o.rx_hi && !clr_i.rx_hi) |=> stat_o.rx_hi);

    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_o.rx_hi && !en_o.tx_lo) |-> !irq_o);

endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tx_pop,
    output logic              tx_avail,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              rx_push,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              rx_space,
    output logic              irq
);

    logic wr_tx_d, wr_ctl_d, wr_ien_d, wr_ist_d, rd_rx_d;
    logic tx_flush_d, rx_flush_d;
    flag_pair_t clr_d, en_wdata_d, stat_q, en_q;
    logic [BYTE_W-1:0] rx_head_q;
    logic [CNT_W-1:0]  tx_cnt_q, rx_cnt_q;
    logic tx_full_q, tx_empty_q, rx_full_q, rx_empty_q;

    always_comb begin
        wr_tx_d    = bus_wr && (bus_addr == OFS_TXDATA);
        wr_ctl_d   = bus_wr && (bus_addr == OFS_CTRL);
        wr_ien_d   = bus_wr && (bus_addr == OFS_IEN);
        wr_ist_d   = bus_wr && (bus_addr == OFS_ISTAT);
        rd_rx_d    = bus_rd && (bus_addr == OFS_RXDATA);
        tx_flush_d = wr_ctl_d && bus_wdata[BIT_TX_FLUSH];
        rx_flush_d = wr_ctl_d && bus_wdata[BIT_RX_FLUSH];
        clr_d.rx_hi      = wr_ist_d && bus_wdata[BIT_RX_HI];
        clr_d.tx_lo      = wr_ist_d && bus_wdata[BIT_TX_LO];
        en_wdata_d.rx_hi = bus_wdata[BIT_RX_HI];
        en_wdata_d.tx_lo = bus_wdata[BIT_TX_LO];
    end

    sync_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_tx_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (tx_flush_d),
        .push_i  (wr_tx_d),
        .wdata_i (bus_wdata[BYTE_W-1:0]),
        .pop_i   (tx_pop),
        .rdata_o (tx_byte),
        .count_o (tx_cnt_q),
        .full_o  (tx_full_q),
        .empty_o (tx_empty_q)
    );

    sync_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_rx_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (rx_flush_d),
        .push_i  (rx_push),
        .wdata_i (rx_byte),
        .pop_i   (rd_rx_d),
        .rdata_o (rx_head_q),
        .count_o (rx_cnt_q),
        .full_o  (rx_full_q),
        .empty_o (rx_empty_q)
    );

    level_flags #(.DEPTH(DEPTH)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_count_i (rx_cnt_q),
        .tx_count_i (tx_cnt_q),
        .clr_i      (clr_d),
        .en_we_i    (wr_ien_d),
        .en_wdata_i (en_wdata_d),
        .stat_o     (stat_q),
        .en_o       (en_q),
        .irq_o      (irq)
    );

    assign tx_avail = !tx_empty_q;
    assign rx_space = !rx_full_q;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_RXDATA: bus_rdata[BYTE_W-1:0] = rx_head_q;
            OFS_IEN: begin
                bus_rdata[BIT_RX_HI] = en_q.rx_hi;
                bus_rdata[BIT_TX_LO] = en_q.tx_lo;
            end
            OFS_ISTAT: begin
                bus_rdata[BIT_RX_HI] = stat_q.rx_hi;
                bus_rdata[BIT_TX_LO] = stat_q.tx_lo;
            end
            OFS_LEVEL: begin
                bus_rdata[LVL_RX_LSB +: LVL_FIELD_W] = LVL_FIELD_W'(rx_cnt_q);
                bus_rdata[LVL_TX_LSB +: LVL_FIELD_W] = LVL_FIELD_W'(tx_cnt_q);
            end
            default: bus_rdata = '0;
        endcase
    end

    p_avail_matches_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop && !tx_full_q && !wr_tx_d && !tx_flush_d && tx_cnt_q == CNT_W'(1)) |=> !tx_avail);

    p_empty_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx_d && rx_empty_q) |-> (bus_rdata == '0));

    p_rx_full_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !rx_space && !rd_rx_d && !rx_flush_d) |=> !rx_space);

endmodule

// File: tb/spi_fifo_pair_test.sv
module spi_fifo_pair_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_pop = 1'b0, tx_avail;
    logic [7:0]  tx_byte;
    logic        rx_push = 1'b0, rx_space;
    logic [7:0]  rx_byte = '0;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    spi_fifo_pair uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_pop(tx_pop), .tx_avail(tx_avail), .tx_byte(tx_byte),
        .rx_push(rx_push), .rx_byte(rx_byte), .rx_space(rx_space), .irq(irq)
    );

    function automatic logic [7:0] tx_pat(input int i);
        return 8'((i * 37 + 5) % 256);
    endfunction

    function automatic logic [7:0] rx_pat(input int i);
        return 8'((i * 11 + 200) % 256);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Every task is entered just after a falling edge and returns at the next one.
    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic sh_pop(output logic avail, output logic [7:0] b);
        tx_pop = 1'b1;
        #1 avail = tx_avail; b = tx_byte;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic sh_push(input logic [7:0] b);
        rx_push = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    function automatic logic [31:0] lvl(input int rx, input int tx);
        return (32'(tx) << 16) | 32'(rx);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic        av;
        logic [7:0]  b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        bus_read(6'h10, d); chk("R11 status after reset", d, 32'h0);
        bus_read(6'h28, d); chk("R11 levels after reset", d, 32'h0);
        bus_read(6'h0C, d); chk("R11 enables after reset", d, 32'h0);
        chk("R11 irq after reset", {31'b0, irq}, 32'h0);
        bus_read(6'h10, d); chk("R7 tx flag with empty queue", d, 32'h1000);

        // R1 R2 R4 transmit fill sweep with overflow
        for (int i = 0; i <= 64; i++) begin
            bus_write(6'h04, {24'hABCDEF, (i == 64) ? 8'hEE : tx_pat(i)});
            bus_read(6'h28, d);
            chk("R1 R4 tx level during fill", d, lvl(0, (i < 64) ? i + 1 : 64));
        end

        // R7 exact boundary during drain, R2 order
        bus_write(6'h10, 32'hFFFF_FFFF);
        for (int i = 0; i < 64; i++) begin
            sh_pop(av, b);
            chk("R2 tx avail", {31'b0, av}, 32'h1);
            chk("R2 tx byte order", {24'b0, b}, {24'b0, tx_pat(i)});
            bus_read(6'h10, d);
            chk("R7 tx flag vs level", d, (64 - i <= 16) ? 32'h1000 : 32'h0);
        end
        sh_pop(av, b);
        chk("R10 tx avail when empty", {31'b0, av}, 32'h0);
        chk("R10 tx byte when empty", {24'b0, b}, 32'h0);
        bus_read(6'h28, d); chk("R10 tx level after empty pop", d, 32'h0);

        // R6 R10 receive fill sweep
        bus_write(6'h10, 32'h0000_0010);
        for (int i = 0; i <= 64; i++) begin
            sh_push((i == 64) ? 8'h5A : rx_pat(i));
            bus_read(6'h10, d);
            chk("R6 rx flag vs level", d, 32'h1000 | ((i >= 48) ? 32'h10 : 32'h0));
            bus_read(6'h28, d);
            chk("R10 rx level during fill", d, lvl((i < 64) ? i + 1 : 64, 0));
        end
        chk("R10 rx space when full", {31'b0, rx_space}, 32'h0);

        // R8 selective clear and re-assertion
        bus_write(6'h10, 32'h0000_0010);
        bus_read(6'h10, d); chk("R8 rx bit cleared, tx kept", d, 32'h1000);
        bus_read(6'h10, d); chk("R8 rx bit sets again", d, 32'h1010);
        bus_write(6'h10, 32'h0);
        bus_read(6'h10, d); chk("R8 zero write keeps flags", d, 32'h1010);

        // R9 enables and irq
        bus_write(6'h0C, 32'hFFFF_FFFF);
        bus_read(6'h0C, d); chk("R9 enable readback", d, 32'h1010);
        bus_write(6'h0C, 32'h0);
        #1 chk("R9 irq off with no enables", {31'b0, irq}, 32'h0);
        bus_write(6'h0C, 32'h10);
        #1 chk("R9 irq from rx flag", {31'b0, irq}, 32'h1);
        bus_write(6'h0C, 32'h1000);
        #1 chk("R9 irq from tx flag", {31'b0, irq}, 32'h1);
        bus_write(6'h10, 32'hFFFF_FFFF);
        #1 chk("R8 R9 irq low after clear", {31'b0, irq}, 32'h0);
        @(negedge clk);
        #1 chk("R8 R9 irq back when condition holds", {31'b0, irq}, 32'h1);
        bus_write(6'h0C, 32'h0);

        // R3 receive drain through the bus
        for (int i = 0; i < 64; i++) begin
            bus_read(6'h00, d);
            chk("R3 rx byte order", d, {24'b0, rx_pat(i)});
        end
        bus_read(6'h00, d); chk("R3 empty read returns zero", d, 32'h0);
        bus_read(6'h28, d); chk("R3 rx level after drain", d, 32'h0);

        // R5 independent flushes
        for (int i = 0; i < 5; i++) bus_write(6'h04, {24'b0, tx_pat(i + 70)});
        for (int i = 0; i < 3; i++) sh_push(rx_pat(i + 70));
        bus_read(6'h28, d); chk("R5 levels before flush", d, lvl(3, 5));
        bus_write(6'h08, 32'h100);
        bus_read(6'h28, d); chk("R5 tx flush only", d, lvl(3, 0));
        bus_write(6'h04, 32'h0000_0033);
        bus_write(6'h04, 32'h0000_0044);
        bus_write(6'h08, 32'h200);
        bus_read(6'h28, d); chk("R5 rx flush only", d, lvl(0, 2));
        sh_pop(av, b); chk("R5 first byte after flush", {24'b0, b}, 32'h33);
        // flush together with a shifter push in the same cycle
        bus_wr = 1'b1; bus_addr = 6'h08; bus_wdata = 32'h200;
        rx_push = 1'b1; rx_byte = 8'h77;
        @(negedge clk);
        bus_wr = 1'b0; rx_push = 1'b0; bus_wdata = '0;
        bus_read(6'h28, d); chk("R5 flush beats push", d, lvl(0, 1));
        bus_read(6'h00, d); chk("R5 rx empty after flush", d, 32'h0);
        bus_read(6'h14, d); chk("R4 unmapped offset reads zero", d, 32'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule